// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block carries out one atomic memory operation at a time against a synchronous single-port memory. A request gives an access size, a memory word address (the caller has already added base and displacement), a source operand, the current value of register zero and an 8-bit operation code. The unit holds a lock on the memory port, reads the addressed location, computes the new value during a separate cycle, writes it back (a failed compare-exchange skips the write), releases the lock and pulses `done`.

With `done` it presents the value the location held before the operation and two write-back flags. One says that the caller must copy that value into the source register. The other says that it must go into register zero. Unsupported sizes and operation codes are reported through `illegal`, and no memory access takes place for them.

The controller has five states. IDLE accepts a request. READ locks the port and issues the read. CALC captures the read data and computes the result. WRITE performs the masked write, or holds the lock without writing. DONE releases the lock and reports. The transitions are: IDLE to READ on a legal request, IDLE to DONE on an illegal one, READ to CALC, CALC to WRITE, WRITE to DONE, and DONE to IDLE.

Top module: `amo_unit`

## Requirements
- R1: After reset `mem_lock`, `mem_re`, `mem_we`, `done`, `illegal`, `wb_src` and `wb_r0` are low and `req_ready` is high.
- R2: A size code of 0 (byte) or 1 (half-word) is rejected. `done` and `illegal` rise one cycle after acceptance, `old_val` is zero and the memory is not accessed. Size code 2 is a 32-bit word and size code 3 is a 64-bit double word.
- R3: An operation code other than 0x00, 0x01, 0x40, 0x41, 0x50, 0x51, 0xA0, 0xA1, 0xE1 and 0xF1 is rejected in the same way as in R2, and the memory content is left unchanged.
- R4: Codes 0x00/0x01 store old+src, 0x40/0x41 store old|src, 0x50/0x51 store old&src and 0xA0/0xA1 store old^src.
- R5: On a 32-bit operation the arithmetic wraps at 32 bits and only the low 32 bits are compared. Byte enables 0x0F keep the upper four bytes of the location. Every returned value is zero-extended to 64 bits.
- R6: Bit 0 of the operation code requests a fetch. On a simple operation with bit 0 set, `wb_src` is high with `done`. With bit 0 clear, `wb_src` stays low. `old_val` always carries the pre-operation value.
- R7: Code 0xE1 (exchange) stores src and raises `wb_src`.
- R8: Code 0xF1 (compare-exchange) stores src only when the old value equals the R0 operand. It always raises `wb_r0` and never raises `wb_src`.
- R9: For a legal request `mem_lock` is high from the read cycle through the write cycle. The write comes two cycles after the read, `done` follows with the lock low, and `done` is a one-cycle pulse four cycles after acceptance.
- R10: `req_ready` is low from acceptance until `done` has been given. A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Unit idle, able to take a request |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 double word |
| req_addr | input | ADDR_W | Memory word address |
| req_src | input | 64 | Source operand |
| req_r0 | input | 64 | Register-zero operand for compare-exchange |
| req_op | input | 8 | Operation code |
| mem_lock | output | 1 | Exclusive hold on the memory port |
| mem_re | output | 1 | Read strobe; data returns the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 64 | Write data |
| mem_wmask | output | 8 | Byte enables for the write |
| mem_rdata | input | 64 | Read data, valid one cycle after `mem_re` |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Request rejected (valid with `done`) |
| old_val | output | 64 | Zero-extended pre-operation value (valid with `done`) |
| wb_src | output | 1 | Write `old_val` to the source register |
| wb_r0 | output | 1 | Write `old_val` to register zero |

## Verification
The bench builds the unit with `ADDR_W` = 4, so the memory model is a 16-entry array. Every location can be preloaded with patterns that straddle the 32-bit boundary, and each location can be read back after every operation to confirm writes, masked writes and skipped writes. The data width stays at 64, so a single run exercises both the word path, with its wrap, zero-extension and preserved upper half, and the double-word path.

// File: rtl/amo_pkg.sv
package amo_pkg;

    typedef enum logic [2:0] {
        OP_ADD,
        OP_OR,
        OP_AND,
        OP_XOR,
        OP_XCHG,
        OP_CMPX
    } amo_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } amo_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CALC,
        ST_WRITE,
        ST_DONE
    } amo_state_e;

    typedef struct packed {
        amo_op_e op;
        logic    fetch;
        logic    legal;
        logic    wide;
    } amo_dec_t;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
(
    input  logic [7:0] op_code,
    input  logic [1:0] size_code,
    output amo_dec_t   dec
);

    logic    op_ok;
    amo_op_e op_sel;

    always_comb begin
        op_ok  = 1'b1;
        op_sel = OP_ADD;
        unique case (op_code)
            8'h00, 8'h01: op_sel = OP_ADD;
            8'h40, 8'h41: op_sel = OP_OR;
            8'h50, 8'h51: op_sel = OP_AND;
            8'hA0, 8'hA1: op_sel = OP_XOR;
            8'hE1:        op_sel = OP_XCHG;
            8'hF1:        op_sel = OP_CMPX;
            default:      op_ok  = 1'b0;
        endcase
    end

    always_comb begin
        dec.op    = op_sel;
        dec.fetch = op_code[0];
        dec.wide  = (size_code == SZ_DWORD);
        dec.legal = op_ok && ((size_code == SZ_WORD) || (size_code == SZ_DWORD));
    end

endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  amo_op_e             op,
    input  logic                wide,
    input  logic [DATA_W-1:0]   rd_raw,
    input  logic [DATA_W-1:0]   src,
    input  logic [DATA_W-1:0]   r0,
    output logic [DATA_W-1:0]   old_ext,
    output logic [DATA_W-1:0]   new_val,
    output logic                do_write,
    output logic [DATA_W/8-1:0] wmask
);

    localparam int HALF_W = DATA_W / 2;
    localparam int NBYTES = DATA_W / 8;
    localparam int HBYTES = NBYTES / 2;

    logic [DATA_W-1:0] src_ext;
    logic [DATA_W-1:0] r0_ext;
    logic [DATA_W-1:0] raw_res;
    logic              match;

    always_comb begin
        old_ext = wide ? rd_raw : {{HALF_W{1'b0}}, rd_raw[HALF_W-1:0]};
        src_ext = wide ? src    : {{HALF_W{1'b0}}, src[HALF_W-1:0]};
        r0_ext  = wide ? r0     : {{HALF_W{1'b0}}, r0[HALF_W-1:0]};
        match   = (old_ext == r0_ext);
    end

    always_comb begin
        raw_res  = src_ext;
        do_write = 1'b1;
        unique case (op)
            OP_ADD:  raw_res = old_ext + src_ext;
            OP_OR:   raw_res = old_ext | src_ext;
            OP_AND:  raw_res = old_ext & src_ext;
            OP_XOR:  raw_res = old_ext ^ src_ext;
            OP_XCHG: raw_res = src_ext;
            OP_CMPX: begin
                raw_res  = src_ext;
                do_write = match;
            end
            default: raw_res = src_ext;
        endcase
        new_val = wide ? raw_res : {{HALF_W{1'b0}}, raw_res[HALF_W-1:0]};
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_mask
        assign wmask[b] = wide || (b < HBYTES);
    end

endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_size,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_src,
    input  logic [DATA_W-1:0]   req_r0,
    input  logic [7:0]          req_op,
    output logic                mem_lock,
    output logic                mem_re,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic [DATA_W/8-1:0] mem_wmask,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                done,
    output logic                illegal,
    output logic [DATA_W-1:0]   old_val,
    output logic                wb_src,
    output logic                wb_r0
);

    localparam int NBYTES = DATA_W / 8;

    amo_state_e        state_q, state_d;
    amo_dec_t          dec_in, dec_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] src_q, r0_q, old_q, new_q;
    logic              wr_q;
    logic [DATA_W-1:0] alu_old, alu_new;
    logic              alu_wr;
    logic [NBYTES-1:0] alu_mask;
    logic              accept;

    amo_decode u_dec (
        .op_code   (req_op),
        .size_code (req_size),
        .dec       (dec_in)
    );

    amo_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (dec_q.op),
        .wide     (dec_q.wide),
        .rd_raw   (mem_rdata),
        .src      (src_q),
        .r0       (r0_q),
        .old_ext  (alu_old),
        .new_val  (alu_new),
        .do_write (alu_wr),
        .wmask    (alu_mask)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = dec_in.legal ? ST_READ : ST_DONE;
            ST_READ:  state_d = ST_CALC;
            ST_CALC:  state_d = ST_WRITE;
            ST_WRITE: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q  <= '0;
            addr_q <= '0;
            src_q  <= '0;
            r0_q   <= '0;
            old_q  <= '0;
            new_q  <= '0;
            wr_q   <= 1'b0;
        end else if (accept) begin
            dec_q  <= dec_in;
            addr_q <= req_addr;
            src_q  <= req_src;
            r0_q   <= req_r0;
            old_q  <= '0;
            wr_q   <= 1'b0;
        end else if (state_q == ST_CALC) begin
            old_q <= alu_old;
            new_q <= alu_new;
            wr_q  <= alu_wr;
        end
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_lock  = 1'b0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        done      = 1'b0;
        illegal   = 1'b0;
        wb_src    = 1'b0;
        wb_r0     = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = new_q;
        mem_wmask = dec_q.wide ? {NBYTES{1'b1}} : alu_mask;
        old_val   = old_q;
        unique case (state_q)
            ST_IDLE:  ;
            ST_READ: begin
                mem_lock = 1'b1;
                mem_re   = 1'b1;
            end
            ST_CALC:  mem_lock = 1'b1;
            ST_WRITE: begin
                mem_lock = 1'b1;
                mem_we   = wr_q;
            end
            ST_DONE: begin
                done    = 1'b1;
                illegal = !dec_q.legal;
                wb_src  = dec_q.legal && dec_q.fetch && (dec_q.op != OP_CMPX);
                wb_r0   = dec_q.legal && (dec_q.op == OP_CMPX);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic mem_lock,
    input logic mem_re,
    input logic mem_we,
    input logic done,
    input logic illegal,
    input logic wb_src,
    input logic wb_r0
);

    p_we_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_lock);

    p_re_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> mem_lock);

    p_write_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(mem_re, 2));

    p_done_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_lock);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_illegal_no_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> !$past(mem_lock));

    p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(wb_src && wb_r0));

    p_flags_need_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !(wb_src || wb_r0 || illegal));

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock || done) |-> !req_ready);

endmodule

bind amo_unit amo_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_lock  (mem_lock),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .done      (done),
    .illegal   (illegal),
    .wb_src    (wb_src),
    .wb_r0     (wb_r0)
);

// File: tb/amo_unit_tb.sv
module amo_unit_tb;

    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_size = '0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0]   req_src = '0;
    logic [63:0]   req_r0 = '0;
    logic [7:0]    req_op = '0;
    logic          mem_lock, mem_re, mem_we;
    logic [AW-1:0] mem_addr;
    logic [63:0]   mem_wdata;
    logic [7:0]    mem_wmask;
    logic [63:0]   mem_rdata = '0;
    logic          done, illegal, wb_src, wb_r0;
    logic [63:0]   old_val;

    logic [63:0] ram [16];
    int cyc = 0;
    int errors = 0;
    int checks = 0;
    bit finished = 0;

    typedef struct {
        logic [63:0]   old;
        logic          ill;
        logic          wbs;
        logic          wbr;
        logic [AW-1:0] addr;
        logic [63:0]   mem_after;
        int            due;
        string         tag;
    } item_t;

    item_t sb[$];

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_re) mem_rdata <= ram[mem_addr];
        if (mem_we)
            for (int b = 0; b < 8; b++)
                if (mem_wmask[b]) ram[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
    end

    amo_unit #(.ADDR_W(AW), .DATA_W(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_size(req_size), .req_addr(req_addr), .req_src(req_src),
        .req_r0(req_r0), .req_op(req_op), .mem_lock(mem_lock), .mem_re(mem_re),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wmask(mem_wmask), .mem_rdata(mem_rdata), .done(done),
        .illegal(illegal), .old_val(old_val), .wb_src(wb_src), .wb_r0(wb_r0)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] zx(input logic [63:0] v, input bit w);
        return w ? v : {32'h0, v[31:0]};
    endfunction

    task automatic issue(input logic [1:0] sz, input logic [AW-1:0] a, input logic [63:0] s,
                         input logic [63:0] r, input logic [7:0] op, input string tag,
                         input bit poke_busy);
        item_t it;
        bit legal, w, wr;
        logic [63:0] cur, o, nv;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        w     = (sz == 2'd3);
        legal = (sz >= 2'd2) && (op inside {8'h00, 8'h01, 8'h40, 8'h41, 8'h50,
                                            8'h51, 8'hA0, 8'hA1, 8'hE1, 8'hF1});
        cur = ram[a];
        o   = zx(cur, w);
        wr  = 1;
        case (op & 8'hFE)
            8'h00:   nv = o + zx(s, w);
            8'h40:   nv = o | zx(s, w);
            8'h50:   nv = o & zx(s, w);
            8'hA0:   nv = o ^ zx(s, w);
            8'hF0: begin nv = zx(s, w); wr = (o == zx(r, w)); end
            default: nv = zx(s, w);
        endcase
        it.old  = legal ? o : 64'h0;
        it.ill  = !legal;
        it.wbs  = legal && op[0] && (op != 8'hF1);
        it.wbr  = legal && (op == 8'hF1);
        it.addr = a;
        it.mem_after = (legal && wr) ? (w ? nv : {cur[63:32], nv[31:0]}) : cur;
        it.due  = cyc + (legal ? 4 : 1);
        it.tag  = tag;
        sb.push_back(it);
        req_valid = 1; req_size = sz; req_addr = a; req_src = s; req_r0 = r; req_op = op;
        @(negedge clk);
        req_valid = 0;
        if (poke_busy && legal) begin
            check(req_ready == 1'b0, "R10 ready low while busy", {63'h0, req_ready}, 64'h0);
            req_valid = 1; req_op = 8'hE1; req_src = 64'hDEAD_BEEF_DEAD_BEEF; req_size = 2'd3;
            repeat (3) @(negedge clk);
            req_valid = 0;
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sb.size() == 0) begin
                    check(0, "R10 unexpected completion", 64'h1, 64'h0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(old_val == it.old, {it.tag, " old value"}, old_val, it.old);
                    check({illegal, wb_src, wb_r0} == {it.ill, it.wbs, it.wbr},
                          {it.tag, " flags ill/src/r0"},
                          {61'h0, illegal, wb_src, wb_r0}, {61'h0, it.ill, it.wbs, it.wbr});
                    check(cyc == it.due, {it.tag, " R9 latency"}, 64'(cyc), 64'(it.due));
                    check(ram[it.addr] == it.mem_after, {it.tag, " memory"},
                          ram[it.addr], it.mem_after);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) ram[i] = {32'hA5A5_0000 + 32'(i), 32'h0F0F_0000 + 32'(i)};
        ram[1] = 64'h1111_2222_FFFF_FFFF;
        ram[2] = 64'hAAAA_BBBB_FFFF_FFF0;
        ram[3] = 64'h0000_00FF_00F0_F0F0;
        ram[4] = 64'h1234_5678_9ABC_DEF0;
        ram[5] = 64'h8000_0000_0000_0001;
        ram[6] = 64'hCAFE_0000_1357_2468;
        repeat (3) @(negedge clk);
        check({mem_lock, mem_re, mem_we, done} == 4'b0, "R1 memory strobes in reset",
              {60'h0, mem_lock, mem_re, mem_we, done}, 64'h0);
        rst_n = 1;
        @(negedge clk);
        check({illegal, wb_src, wb_r0} == 3'b0 && req_ready, "R1 idle after reset",
              {60'h0, req_ready, illegal, wb_src, wb_r0}, 64'h8);

        issue(2'd3, 4'd1, 64'h1, 0, 8'h01, "R4 R6 add64 fetch", 0);
        issue(2'd3, 4'd3, 64'hFF00_0000_0F0F_0F0F, 0, 8'h40, "R4 R6 or64 nofetch", 0);
        issue(2'd3, 4'd4, 64'hFFFF_0000_FFFF_0000, 0, 8'h51, "R4 and64 fetch", 0);
        issue(2'd3, 4'd6, 64'hFFFF_FFFF_0000_0000, 0, 8'hA0, "R4 xor64", 0);
        issue(2'd2, 4'd2, 64'hFFFF_FFFF_0000_0020, 0, 8'h01, "R5 add32 wrap", 0);
        issue(2'd2, 4'd5, 64'h0, 0, 8'hA1, "R5 xor32 keeps upper", 0);
        issue(2'd3, 4'd7, 64'h0102_0304_0506_0708, 0, 8'hE1, "R7 xchg64", 0);
        issue(2'd2, 4'd8, 64'hFFFF_FFFF_7777_8888, 0, 8'hE1, "R7 R5 xchg32", 0);
        issue(2'd3, 4'd4, 64'h5555, ram[4], 8'hF1, "R8 cmpx64 hit", 0);
        issue(2'd3, 4'd4, 64'h6666, 64'h1, 8'hF1, "R8 cmpx64 miss", 0);
        issue(2'd2, 4'd9, 64'h4444_4444, {32'hFFFF_FFFF, ram[9][31:0]}, 8'hF1, "R8 R5 cmpx32 hit", 0);
        issue(2'd2, 4'd9, 64'h9, 64'h0, 8'hF1, "R8 cmpx32 miss", 0);
        issue(2'd3, 4'd10, 64'h1, 0, 8'hE0, "R3 bad code xchg nofetch", 0);
        issue(2'd3, 4'd10, 64'h1, 0, 8'h10, "R3 bad code", 0);
        issue(2'd2, 4'd10, 64'h1, 0, 8'hF0, "R3 bad code cmpx nofetch", 0);
        issue(2'd0, 4'd11, 64'h1, 0, 8'h00, "R2 byte size", 0);
        issue(2'd1, 4'd11, 64'h1, 0, 8'hE1, "R2 half size", 0);
        issue(2'd3, 4'd12, 64'h10, 0, 8'h00, "R10 busy request ignored", 1);
        issue(2'd3, 4'd12, 64'h1, 0, 8'h01, "R9 back to back", 0);
        repeat (8) @(negedge clk);
        check(sb.size() == 0, "R9 all completions seen", 64'(sb.size()), 64'h0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule